// File: doc/BRIEF.md
# Standby Controller with Settling Timer

This block governs the low-power states of a small processor. Software programs a five-bit control word holding three things: a standby-enable flag, a three-bit wake-delay selector and a bus-keep flag. When the core raises a sleep request, the controller picks its target from the standby-enable flag.

- **Light sleep:** the core clock stops and the peripheral clock keeps running. Any interrupt returns the block to normal operation on the next cycle.
- **Deep standby:** both clock enables drop and the bus is either floated or parked. An external interrupt then starts a down-counter that holds everything halted while the oscillator stabilises. The clock enables come back only when the count expires.

The wake delay is a power of two picked by the selector. The mapping is not monotonic: one code gives a very short delay, and the last code is reserved. The reserved code falls back to the longest delay and raises an error flag, so the block never wakes without a delay. The parameter `BASE_LOG2` scales every delay. Its default of 13 gives the intended range of 1,024 to 262,144 cycles.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset the control word reads 0, `mode` is 00 (normal), both clock enables are 1, and `bus_float`, `bus_park` and `sel_err` are 0.
- R2: A write stores `reg_wdata` in the control word. Bit 0 is standby-enable, bits 3:1 are the wake-delay selector and bit 4 is bus-keep. `reg_rdata` returns the stored word on the cycle after the write.
- R3: In normal mode, a sampled `sleep_req` with standby-enable 0 gives `mode` 01 (sleep) on the next cycle. In sleep, `cpu_clk_en` is 0 and `per_clk_en` is 1.
- R4: In sleep, a sampled `irq_pend` or `ext_irq` returns `mode` to 00 on the next cycle, with no settling phase.
- R5: In normal mode, a sampled `sleep_req` with standby-enable 1 gives `mode` 10 (standby) on the next cycle, with both clock enables at 0. In standby, `irq_pend` has no effect.
- R6: A sampled `ext_irq` in standby gives `mode` 11 (settling). The block stays in settling for exactly N cycles with both clock enables at 0, then shows `mode` 00 with both enables at 1.
- R7: N is set by the selector: code c in 0..5 gives 2^(BASE_LOG2+c), and code 6 gives 2^(BASE_LOG2-3).
- R8: Selector code 7 drives `sel_err` to 1 and gives N = 2^(BASE_LOG2+5), the longest delay. Every other code gives `sel_err` 0.
- R9: In standby and settling, bus-keep 0 gives `bus_float`=1 and `bus_park`=0, and bus-keep 1 gives `bus_float`=0 and `bus_park`=1. In normal and sleep, both are 0.
- R10: Standby-enable stays 1 after waking from standby. Only a software write of 0 clears it.
- R11: `sleep_req` has no effect outside normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control-word write strobe |
| reg_wdata | input | 5 | Control-word write data |
| reg_rdata | output | 5 | Control-word readback |
| sleep_req | input | 1 | Sleep request from the core |
| irq_pend | input | 1 | Any enabled interrupt pending (wakes sleep only) |
| ext_irq | input | 1 | External interrupt (wakes sleep or standby) |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| bus_float | output | 1 | Address bus and strobes to high impedance |
| bus_park | output | 1 | Address held, strobes driven high |
| mode | output | 2 | 00 normal, 01 sleep, 10 standby, 11 settling |
| sel_err | output | 1 | Reserved wake-delay code programmed |

## Verification
The bench measures the settling length for every selector code. It targets two errors:
- A sorted table would get code 6 wrong.
- A missing fallback would wake at once, or after a wrong delay, on code 7.

An off-by-one in the counter load or in the exit compare shows up as a settling phase one cycle long or short. The bench checks that standby ignores ordinary interrupts, that sleep wakes with no count, and that sleep requests outside normal mode are dropped. It also checks that standby-enable survives a wake-up, so a design that cleared it on wake would enter sleep on the next request.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

   typedef enum logic [1:0] {
      PM_RUN    = 2'b00,
      PM_SLEEP  = 2'b01,
      PM_STBY   = 2'b10,
      PM_SETTLE = 2'b11
   } pm_state_e;

   // control word: bit4 bus_keep, bits3:1 wait_sel, bit0 stby_en
   typedef struct packed {
      logic       bus_keep;
      logic [2:0] wait_sel;
      logic       stby_en;
   } pm_ctl_t;

   localparam int CTL_W   = $bits(pm_ctl_t);
   localparam int NCODES  = 8;
   localparam int NLINEAR = 6;

endpackage

// File: rtl/pwrdn_ctl_reg.sv
module pwrdn_ctl_reg
   import pwrdn_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output pm_ctl_t          ctl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl <= '0;
      else if (wr_en)
         ctl <= pm_ctl_t'(wr_data);
   end

   // R10: the word changes only through a write
   a_r10_ctl_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctl));

   // R2: a write lands on the next cycle
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctl == pm_ctl_t'($past(wr_data))));

endmodule

// File: rtl/pwrdn_wait_sel.sv
module pwrdn_wait_sel
   import pwrdn_pkg::*;
#(
   parameter int BASE_LOG2 = 13,
   parameter int CNT_W     = BASE_LOG2 + 5
)(
   input  logic [2:0]       sel,
   output logic [CNT_W-1:0] load_val,
   output logic             sel_err
);

   localparam int LONG_EXP = BASE_LOG2 + NLINEAR - 1;

   if (BASE_LOG2 < 3) begin : g_bad_base
      $error("pwrdn_wait_sel: BASE_LOG2 must be at least 3");
   end
   if (CNT_W < LONG_EXP) begin : g_bad_width
      $error("pwrdn_wait_sel: CNT_W too small for the longest wait");
   end

   logic [CNT_W-1:0] tbl [NCODES];

   for (genvar i = 0; i < NCODES; i++) begin : g_code
      localparam int EXP = (i < NLINEAR) ? (BASE_LOG2 + i) :
                           (i == NLINEAR) ? (BASE_LOG2 - 3) : LONG_EXP;
      // counter is loaded with N-1 so the wait lasts N cycles
      assign tbl[i] = CNT_W'((64'd1 << EXP) - 64'd1);
   end

   always_comb begin
      load_val = tbl[sel];
      sel_err  = (sel == 3'(NCODES - 1));
   end

   // R8: the reserved code must fall back to the longest wait
   always_comb begin
      if (sel == 3'b111)
         a_r8_fallback: assert (load_val == CNT_W'((64'd1 << LONG_EXP) - 64'd1));
   end

endmodule

// File: rtl/pwrdn_settle_cnt.sv
module pwrdn_settle_cnt #(
   parameter int CNT_W = 18
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             done
);

   if (CNT_W < 2) begin : g_bad_w
      $error("pwrdn_settle_cnt: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (run && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   // R6: one step per cycle while settling
   a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !done) |=> (cnt == $past(cnt) - 1'b1));

   // R6: the count never wraps
   a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && done) |=> done);

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
   import pwrdn_pkg::*;
#(
   parameter int BASE_LOG2 = 13,
   parameter int CNT_W     = BASE_LOG2 + 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [CTL_W-1:0] reg_wdata,
   output logic [CTL_W-1:0] reg_rdata,
   input  logic             sleep_req,
   input  logic             irq_pend,
   input  logic             ext_irq,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             bus_float,
   output logic             bus_park,
   output logic [1:0]       mode,
   output logic             sel_err
);

   pm_ctl_t          ctl;
   pm_state_e        state, state_nx;
   logic [CNT_W-1:0] load_val;
   logic             settle_load, settle_done, halted;

   pwrdn_ctl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_data (reg_wdata),
      .ctl     (ctl)
   );

   pwrdn_wait_sel #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_sel (
      .sel      (ctl.wait_sel),
      .load_val (load_val),
      .sel_err  (sel_err)
   );

   assign settle_load = (state == PM_STBY) && ext_irq;

   pwrdn_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (settle_load),
      .load_val (load_val),
      .run      (state == PM_SETTLE),
      .done     (settle_done)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         PM_RUN:    if (sleep_req) state_nx = ctl.stby_en ? PM_STBY : PM_SLEEP;
         PM_SLEEP:  if (irq_pend || ext_irq) state_nx = PM_RUN;
         PM_STBY:   if (ext_irq) state_nx = PM_SETTLE;
         PM_SETTLE: if (settle_done) state_nx = PM_RUN;
         default:   state_nx = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PM_RUN;
      else        state <= state_nx;
   end

   assign halted     = (state == PM_STBY) || (state == PM_SETTLE);
   assign cpu_clk_en = (state == PM_RUN);
   assign per_clk_en = (state == PM_RUN) || (state == PM_SLEEP);
   assign bus_float  = halted && !ctl.bus_keep;
   assign bus_park   = halted && ctl.bus_keep;
   assign mode       = state;
   assign reg_rdata  = ctl;

   a_r3_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_RUN && sleep_req && !ctl.stby_en) |=> (mode == 2'b01));

   a_r5_enter_stby: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_RUN && sleep_req && ctl.stby_en) |=> (mode == 2'b10));

   a_r4_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_SLEEP && (irq_pend || ext_irq)) |=> cpu_clk_en);

   a_r5_stby_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_STBY && !ext_irq) |=> (mode == 2'b10));

   a_r6_settle_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_SETTLE && settle_done) |=> (cpu_clk_en && per_clk_en));

   a_r6_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_SETTLE && !settle_done) |=> !per_clk_en);

   a_r11_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_SLEEP && !irq_pend && !ext_irq) |=> (mode == 2'b01));

   a_r9_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_float && bus_park));

endmodule

// File: tb/pwrdn_ctrl_tb.sv
module pwrdn_ctrl_tb;

   localparam int B = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [4:0] reg_wdata = '0;
   logic [4:0] reg_rdata;
   logic       sleep_req = 1'b0, irq_pend = 1'b0, ext_irq = 1'b0;
   logic       cpu_clk_en, per_clk_en, bus_float, bus_park, sel_err;
   logic [1:0] mode;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   pwrdn_ctrl #(.BASE_LOG2(B)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .sleep_req(sleep_req), .irq_pend(irq_pend),
      .ext_irq(ext_irq), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
      .bus_float(bus_float), .bus_park(bus_park), .mode(mode), .sel_err(sel_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_wait(input int code);
      if (code < 6)       return 1 << (B + code);
      else if (code == 6) return 1 << (B - 3);
      else                return 1 << (B + 5);
   endfunction

   task automatic wr(input logic [4:0] d);
      @(negedge clk); reg_wr_en = 1'b1; reg_wdata = d;
      @(negedge clk); reg_wr_en = 1'b0;
   endtask

   task automatic pulse_sleep();
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 rdata", reg_rdata, 0);
      chk("R1 mode", mode, 0);
      chk("R1 cpu_clk_en", cpu_clk_en, 1);
      chk("R1 per_clk_en", per_clk_en, 1);
      chk("R1 bus", {bus_float, bus_park}, 0);
      chk("R1 sel_err", sel_err, 0);
   endtask

   task automatic t_regs();
      wr(5'b11010);
      chk("R2 readback", reg_rdata, 5'b11010);
      wr(5'b00000);
      chk("R2 cleared", reg_rdata, 0);
   endtask

   task automatic t_sleep(input bit use_ext);
      pulse_sleep();
      chk("R3 mode sleep", mode, 1);
      chk("R3 cpu off", cpu_clk_en, 0);
      chk("R3 per on", per_clk_en, 1);
      chk("R9 bus idle in sleep", {bus_float, bus_park}, 0);
      pulse_sleep();
      chk("R11 sleep_req ignored", mode, 1);
      @(negedge clk);
      if (use_ext) ext_irq = 1'b1; else irq_pend = 1'b1;
      @(negedge clk); ext_irq = 1'b0; irq_pend = 1'b0;
      chk("R4 immediate wake", mode, 0);
      chk("R4 cpu back", cpu_clk_en, 1);
   endtask

   task automatic t_stby(input int code, input bit keep);
      int n;
      wr({keep, 3'(code), 1'b1});
      chk("R8 sel_err flag", sel_err, (code == 7) ? 1 : 0);
      pulse_sleep();
      chk("R5 mode standby", mode, 2);
      chk("R5 clocks off", {cpu_clk_en, per_clk_en}, 0);
      chk("R9 bus in standby", {bus_float, bus_park}, keep ? 2'b01 : 2'b10);
      @(negedge clk); irq_pend = 1'b1; sleep_req = 1'b1;
      @(negedge clk); irq_pend = 1'b0; sleep_req = 1'b0;
      chk("R5 irq_pend ignored", mode, 2);
      @(negedge clk); ext_irq = 1'b1;
      @(negedge clk); ext_irq = 1'b0;
      chk("R6 mode settling", mode, 3);
      chk("R9 bus in settling", {bus_float, bus_park}, keep ? 2'b01 : 2'b10);
      n = 0;
      while (mode == 2'b11 && n < 5000) begin
         if (per_clk_en || cpu_clk_en) begin
            chk("R6 clocks off while settling", {cpu_clk_en, per_clk_en}, 0);
         end
         n++;
         @(negedge clk);
      end
      chk((code == 7) ? "R8 fallback wait" : "R7 wait length", n, exp_wait(code));
      chk("R6 clocks back", {cpu_clk_en, per_clk_en}, 2'b11);
      chk("R9 bus released", {bus_float, bus_park}, 0);
      chk("R10 stby_en kept", reg_rdata[0], 1);
   endtask

   task automatic t_clear();
      pulse_sleep();
      chk("R10 still standby", mode, 2);
      @(negedge clk); ext_irq = 1'b1;
      @(negedge clk); ext_irq = 1'b0;
      while (mode != 2'b00) @(negedge clk);
      wr(5'b00000);
      chk("R10 cleared by write", reg_rdata[0], 0);
      pulse_sleep();
      chk("R10 now sleep", mode, 1);
      @(negedge clk); irq_pend = 1'b1;
      @(negedge clk); irq_pend = 1'b0;
      chk("R4 back to normal", mode, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_sleep(1'b0);
      t_sleep(1'b1);
      for (int c = 0; c < 8; c++) t_stby(c, c[0]);
      t_clear();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule